// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog down-counter that runs from a slow timing reference. It receives that reference as a one-cycle enable, `slow_tick`, in the system clock domain. A power-of-two prescaler divides the slow ticks. Each prescaled tick decrements a 12-bit counter. When a tick arrives while the counter is already zero, the block raises a one-cycle `sys_rst_pulse` and reloads the counter. The reset controller of the chip is expected to act on that pulse.

Software reaches the block through a simple write port and a combinational read port. Four word addresses exist: a key word, a prescaler code, a reload value and a status word. Writing a magic code to the key word does one of four things: it opens or closes write access to the prescaler and reload registers, it refreshes the counter, or it starts the timer. Once the timer runs, only a system reset stops it. A strap input, sampled while the block is held in reset, can start the timer without any software action.

Top module: `key_watchdog`

## Requirements
- R1: After reset the prescaler code reads 0, the reload value reads RLD_INIT (0xFFF by default), the status word reads 0 and `sys_rst_pulse` is low. With `hw_auto_start` low, no pulse ever occurs until a start key is written.
- R2: Address map: 0 = key, 1 = prescaler code in bits 2:0, 2 = reload value in bits 11:0, 3 = status. Key 0x5555 grants write access to addresses 1 and 2, and key 0x0000 withdraws it. While access is withdrawn, writes to addresses 1 and 2 change nothing.
- R3: Any key value other than 0x5555, 0x0000, 0xAAAA and 0xCCCC has no effect.
- R4: Reading address 0 returns zero. Reads of addresses 1 and 2 return the stored prescaler code and reload value, zero-extended to 16 bits.
- R5: Prescaler code n (0 to 6) makes one counter step per 2^(n+2) slow ticks. Code 7 behaves like code 6 (256 ticks per step).
- R6: While running, with reload value R and divider D, `sys_rst_pulse` is high for exactly one cycle after (R+1)*D slow ticks. The counter then reloads, and the next pulse follows (R+1)*D ticks later.
- R7: Key 0xAAAA loads the counter from the reload value and restarts the prescaler count, so the next pulse comes (R+1)*D ticks after that write.
- R8: Key 0xCCCC starts the timer and behaves like 0xAAAA for the count. After that, no key value and no register write stops the pulses.
- R9: Status bit 0 (prescaler update busy) and status bit 1 (reload update busy) go high on an accepted write to address 1 or 2 respectively. Each bit clears after BUSY_TICKS further slow ticks.
- R10: If `hw_auto_start` is high while reset is asserted, the timer runs from reset release with the reset-time settings. The first pulse comes (RLD_INIT+1)*4 slow ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_auto_start | input | 1 | Strap: run from reset without a start key |
| slow_tick | input | 1 | One-cycle enable marking each slow reference tick |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 16 | Combinational read data |
| sys_rst_pulse | output | 1 | One-cycle system reset request on timeout |

## Verification
The bench uses the default parameters: RLD_INIT = 0xFFF, BUSY_TICKS = 4 and a maximum prescaler code of 6. It holds `slow_tick` high, so every clock edge is one slow tick. Under these settings, the full-length power-on timeout of 16384 ticks is short enough to measure exactly for the strap-start case. The 256-tick divider for code 7 can be timed with reload value 0. The 4-tick busy window can be checked edge by edge.

// File: rtl/key_watchdog.sv
module key_watchdog #(
  parameter int RLD_W      = 12,
  parameter int PRE_W      = 3,
  parameter int MAX_CODE   = 6,
  parameter int BUSY_TICKS = 4,
  parameter int RLD_INIT   = 4095
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_auto_start,
  input  logic        slow_tick,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        sys_rst_pulse
);
  localparam int DIV_W = MAX_CODE + 2;
  localparam int BW    = $clog2(BUSY_TICKS + 1);
  localparam logic [15:0] K_OPEN   = 16'h5555;
  localparam logic [15:0] K_CLOSE  = 16'h0000;
  localparam logic [15:0] K_FEED   = 16'hAAAA;
  localparam logic [15:0] K_ARM    = 16'hCCCC;

  logic             unlocked, running;
  logic [PRE_W-1:0] pre, eff;
  logic [RLD_W-1:0] rld, cnt;
  logic [DIV_W-1:0] div_cnt, div_last;
  logic [BW-1:0]    bsy_pre, bsy_rld;

  wire key_wr  = wr_en && (wr_addr == 2'd0);
  wire k_open  = key_wr && (wr_data == K_OPEN);
  wire k_close = key_wr && (wr_data == K_CLOSE);
  wire k_feed  = key_wr && (wr_data == K_FEED);
  wire k_arm   = key_wr && (wr_data == K_ARM);
  wire reload  = k_feed || k_arm;
  wire pre_wr  = wr_en && unlocked && (wr_addr == 2'd1);
  wire rld_wr  = wr_en && unlocked && (wr_addr == 2'd2);

  always_comb begin
    eff      = (pre > PRE_W'(MAX_CODE)) ? PRE_W'(MAX_CODE) : pre;
    div_last = DIV_W'((32'd1 << (32'(eff) + 32'd2)) - 32'd1);
  end

  wire ptick = running && slow_tick && (div_cnt >= div_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked      <= 1'b0;
      running       <= hw_auto_start;
      pre           <= '0;
      rld           <= RLD_W'(RLD_INIT);
      cnt           <= RLD_W'(RLD_INIT);
      div_cnt       <= '0;
      bsy_pre       <= '0;
      bsy_rld       <= '0;
      sys_rst_pulse <= 1'b0;
    end else begin
      if (k_open)       unlocked <= 1'b1;
      else if (k_close) unlocked <= 1'b0;
      if (k_arm) running <= 1'b1;
      if (pre_wr) pre <= wr_data[PRE_W-1:0];
      if (rld_wr) rld <= wr_data[RLD_W-1:0];

      if (pre_wr) bsy_pre <= BW'(BUSY_TICKS);
      else if (slow_tick && bsy_pre != '0) bsy_pre <= bsy_pre - 1'b1;
      if (rld_wr) bsy_rld <= BW'(BUSY_TICKS);
      else if (slow_tick && bsy_rld != '0) bsy_rld <= bsy_rld - 1'b1;

      if (reload) begin
        cnt     <= rld;
        div_cnt <= '0;
      end else if (running && slow_tick) begin
        if (ptick) begin
          div_cnt <= '0;
          cnt     <= (cnt == '0) ? rld : cnt - 1'b1;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
      sys_rst_pulse <= ptick && (cnt == '0) && !reload;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd1:    rd_data = 16'(pre);
      2'd2:    rd_data = 16'(rld);
      2'd3:    rd_data = {14'd0, bsy_rld != '0, bsy_pre != '0};
      default: rd_data = 16'd0;
    endcase
  end

  p_locked_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && wr_addr == 2'd1) |=> $stable(pre));
  p_locked_rld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && wr_addr == 2'd2) |=> $stable(rld));
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |=> !sys_rst_pulse);
  p_pulse_running_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> running);
  p_run_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
  p_busy_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pre_wr |=> (rd_addr != 2'd3 || rd_data[0]));
endmodule

// File: tb/sim_key_watchdog.sv
module sim_key_watchdog;
  logic clk = 1'b0, rst_n = 1'b0, hw_auto_start = 1'b0, slow_tick = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic sys_rst_pulse;
  int checks = 0, failures = 0, cyc = 0;

  always #4 clk = ~clk;

  key_watchdog u0 (.clk(clk), .rst_n(rst_n), .hw_auto_start(hw_auto_start),
    .slow_tick(slow_tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sys_rst_pulse(sys_rst_pulse));

  // rows: {waddr, wdata, raddr, expected read}
  localparam int NV = 11;
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 16'h5555, 2'd0, 16'h0000},
    {2'd1, 16'h0005, 2'd1, 16'h0005},
    {2'd2, 16'h0123, 2'd2, 16'h0123},
    {2'd0, 16'h0000, 2'd0, 16'h0000},
    {2'd1, 16'h0002, 2'd1, 16'h0005},
    {2'd2, 16'h0007, 2'd2, 16'h0123},
    {2'd0, 16'h1234, 2'd1, 16'h0005},
    {2'd2, 16'h0009, 2'd2, 16'h0123},
    {2'd0, 16'h5555, 2'd0, 16'h0000},
    {2'd2, 16'hFFFF, 2'd2, 16'h0FFF},
    {2'd1, 16'h0000, 2'd1, 16'h0000}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wait_pulse(input int n, input string tag);
    int early = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); #1;
      if (i < n && sys_rst_pulse) early++;
      if (i == n) chk(sys_rst_pulse === 1'b1 && early == 0, tag, early, 0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int seen;
    edges(3);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd(2'd1, v); chk(v == 16'h0, "R1 prescaler after reset", v, 0);
    rd(2'd2, v); chk(v == 16'h0FFF, "R1 reload after reset", v, 16'hFFF);
    rd(2'd3, v); chk(v == 16'h0, "R1 status after reset", v, 0);
    chk(sys_rst_pulse == 1'b0, "R1 pulse after reset", sys_rst_pulse, 0);
    seen = 0;
    for (int i = 0; i < 17000; i++) begin @(posedge clk); #1; if (sys_rst_pulse) seen++; end
    chk(seen == 0, "R1 no pulse without start", seen, 0);

    // table walk: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][35:34], VEC[i][33:18]);
      rd(VEC[i][17:16], v);
      chk(v == VEC[i][15:0], $sformatf("R2/R3/R4 table row %0d", i), v, VEC[i][15:0]);
    end
    edges(10);

    // R9 busy flags
    wr(2'd1, 16'h0000);
    rd(2'd3, v); chk(v[0] == 1'b1, "R9 prescaler busy set", v, 1);
    edges(3);
    rd(2'd3, v); chk(v[0] == 1'b1, "R9 prescaler busy held", v, 1);
    edges(1);
    rd(2'd3, v); chk(v[0] == 1'b0, "R9 prescaler busy cleared", v, 0);
    wr(2'd2, 16'h0002);
    rd(2'd3, v); chk(v[1] == 1'b1 && v[0] == 1'b0, "R9 reload busy set", v, 2);
    edges(4);
    rd(2'd3, v); chk(v == 16'h0, "R9 reload busy cleared", v, 0);
    edges(5);

    // R6 R8 start, period 3*4 = 12
    wr(2'd0, 16'hCCCC);
    wait_pulse(12, "R8 R6 first timeout");
    edges(1);
    chk(sys_rst_pulse == 1'b0, "R6 pulse lasts one cycle", sys_rst_pulse, 0);
    wait_pulse(11, "R6 periodic timeout");
    // R7 feed postpones the timeout
    edges(5);
    wr(2'd0, 16'hAAAA);
    wait_pulse(12, "R7 feed restarts count");
    // R8 cannot be stopped
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'hFFFF);
    wr(2'd0, 16'hAAAA);
    wait_pulse(12, "R8 still running after other keys");
    // R5 prescaler codes
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0007);
    wr(2'd0, 16'hAAAA);
    wait_pulse(256, "R5 code 7 divides by 256");
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'hAAAA);
    wait_pulse(8, "R5 code 1 divides by 8");

    // R10 strap start
    @(negedge clk) begin rst_n = 1'b0; hw_auto_start = 1'b1; end
    edges(2);
    @(negedge clk) rst_n = 1'b1;
    rd(2'd2, v); chk(v == 16'h0FFF, "R1 reload restored by reset", v, 16'hFFF);
    wait_pulse(16384, "R10 strap start timeout");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule